// File: doc/BRIEF.md
# Saturating Hit/Miss Event Monitor

This block keeps two event counters beside a cache lookup stage. One counts lookups that hit and the other counts lookups that miss. The lookup logic gives each counter a one-cycle strobe per event. A four-bit control word gives each counter two controls: a run bit and a hold-at-zero bit. Software updates this word with a whole-word write. To start, stop or clear one counter or both, it writes the word with the bits it wants.

A stopped counter keeps its value. A counter that is running stops at its largest value and never wraps. Both counts appear at all times as full-width outputs. The control word can be read back.

Top module: `hitmiss_monitor`

## Requirements
- R1: A synchronous reset clears both counts and all four control bits to zero.
- R2: The control word layout is bit 0 hit run, bit 1 miss run, bit 2 hit hold-at-zero and bit 3 miss hold-at-zero. Each hold bit sits two places above its run bit. A write with `ctl_wr` high loads `ctl_wdata` at the clock edge, and the new word reads back on `ctl_q` after that edge.
- R3: When the run bit of a counter is set and its hold bit is clear, the counter adds exactly one on the clock edge that samples its strobe high.
- R4: When its run bit is clear, a counter keeps its value through any number of strobes and does not clear.
- R5: A counter at its largest value (all ones, 32 bits by default) stays there and does not wrap to zero.
- R6: While its hold bit is set, a counter reads zero from the edge after the bit is loaded, whatever the state of its run bit and strobe.
- R7: After its hold bit is cleared, a running counter counts up again from zero.
- R8: Each counter counts only its own strobe. Hit and miss strobes in the same cycle are each counted by their own counter.
- R9: Counting can be run for hits only, misses only or both, depending on which run bits are set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_wdata | input | 4 | Control word write data |
| ctl_q | output | 4 | Current control word |
| hit_evt | input | 1 | One-cycle hit strobe |
| miss_evt | input | 1 | One-cycle miss strobe |
| hit_count | output | WIDTH | Hit count |
| miss_count | output | WIDTH | Miss count |

## Verification
The properties assume that the strobes and control writes are steady around the rising edge, and that a strobe high for several cycles stands for one event per cycle. The bench changes every input on the falling clock edge, so the design always samples settled values. The bench uses a 6-bit counter width so that saturation can be reached in a few dozen events. It counts the strobes it sends, clips that count at 63 and compares the result with the outputs.

// File: rtl/hitmiss_monitor.sv
module hitmiss_monitor #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [3:0]       ctl_wdata,
  output logic [3:0]       ctl_q,
  input  logic             hit_evt,
  input  logic             miss_evt,
  output logic [WIDTH-1:0] hit_count,
  output logic [WIDTH-1:0] miss_count
);
  localparam logic [WIDTH-1:0] TOP = '1;

  logic [1:0]       evt;
  logic [WIDTH-1:0] cnt [2];

  assign evt        = {miss_evt, hit_evt};
  assign hit_count  = cnt[0];
  assign miss_count = cnt[1];

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= 4'b0000;
    else if (ctl_wr) ctl_q <= ctl_wdata;
  end

  for (genvar i = 0; i < 2; i++) begin : g_ctr
    logic run, hold, bump;
    assign run  = ctl_q[i];
    assign hold = ctl_q[i+2];
    assign bump = run && evt[i] && (cnt[i] != TOP);

    always_ff @(posedge clk) begin
      if (rst || hold) cnt[i] <= '0;
      else if (bump)   cnt[i] <= cnt[i] + 1'b1;
    end
  end
endmodule

// File: rtl/hitmiss_monitor_chk.sv
module hitmiss_monitor_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       ctl_q,
  input logic             hit_evt,
  input logic             miss_evt,
  input logic [WIDTH-1:0] hit_count,
  input logic [WIDTH-1:0] miss_count
);
  localparam logic [WIDTH-1:0] TOP = '1;

  // R3
  hit_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[0] && !ctl_q[2] && hit_evt && hit_count != TOP) |=> hit_count == WIDTH'($past(hit_count) + 1'b1));
  // R3
  miss_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_q[1] && !ctl_q[3] && miss_evt && miss_count != TOP) |=> miss_count == WIDTH'($past(miss_count) + 1'b1));
  // R4
  hit_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[0] && !ctl_q[2]) |=> $stable(hit_count));
  // R4
  miss_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctl_q[1] && !ctl_q[3]) |=> $stable(miss_count));
  // R5
  hit_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_count == TOP && !ctl_q[2]) |=> hit_count == TOP);
  // R5
  miss_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (miss_count == TOP && !ctl_q[3]) |=> miss_count == TOP);
  // R6
  hit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[2] |=> hit_count == '0);
  // R6
  miss_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_q[3] |=> miss_count == '0);
  // R8
  hit_own_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (!hit_evt && !ctl_q[2]) |=> $stable(hit_count));
  // R8
  miss_own_evt_chk: assert property (@(posedge clk) disable iff (rst)
    (!miss_evt && !ctl_q[3]) |=> $stable(miss_count));
endmodule

bind hitmiss_monitor hitmiss_monitor_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .ctl_q(ctl_q), .hit_evt(hit_evt), .miss_evt(miss_evt),
  .hit_count(hit_count), .miss_count(miss_count)
);

// File: tb/hitmiss_monitor_bench.sv
module hitmiss_monitor_bench;
  localparam int W   = 6;
  localparam int TOP = (1 << W) - 1;

  logic clk = 1'b0, rst = 1'b1, ctl_wr = 1'b0, hit_evt = 1'b0, miss_evt = 1'b0;
  logic [3:0]   ctl_wdata = 4'b0000;
  logic [3:0]   ctl_q;
  logic [W-1:0] hit_count, miss_count;
  int checks = 0, errors = 0, eh = 0, em = 0;
  bit done = 1'b0;

  hitmiss_monitor #(.WIDTH(W)) u_hitmiss_monitor (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_q(ctl_q),
    .hit_evt(hit_evt), .miss_evt(miss_evt), .hit_count(hit_count), .miss_count(miss_count)
  );

  always #4 clk = ~clk;

  function automatic int clip(int v);
    return (v > TOP) ? TOP : v;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] v);
    ctl_wr = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_wr = 1'b0;
  endtask

  task automatic pulses(logic h, logic m, int n);
    for (int i = 0; i < n; i++) begin
      hit_evt = h; miss_evt = m;
      @(negedge clk);
    end
    hit_evt = 1'b0; miss_evt = 1'b0;
  endtask

  task automatic both(string req);
    check({req, " hit"}, int'(hit_count), eh);
    check({req, " miss"}, int'(miss_count), em);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    both("R1 reset");
    check("R1 ctl", int'(ctl_q), 0);

    pulses(1, 1, 7);
    both("R4 idle strobes ignored");

    wr(4'b0001);
    check("R2 readback", int'(ctl_q), 1);
    pulses(1, 1, 5); eh = 5;
    both("R9 hit only");

    wr(4'b0010);
    pulses(1, 1, 3); em = 3;
    both("R4 hit frozen, R9 miss only");

    wr(4'b0011);
    for (int i = 0; i < 24; i++) begin
      hit_evt = i[0]; miss_evt = i[1];
      eh += i[0]; em += i[1];
      @(negedge clk);
    end
    hit_evt = 1'b0; miss_evt = 1'b0;
    both("R8 mixed pattern");

    hit_evt = 1'b1;
    check("R3 before edge", int'(hit_count), eh);
    @(negedge clk);
    hit_evt = 1'b0; eh++;
    check("R3 one edge", int'(hit_count), eh);

    pulses(1, 0, 80); eh = clip(eh + 80);
    both("R5 hit saturates");
    pulses(1, 1, 10); em = clip(em + 10);
    both("R5 stays at top");
    pulses(0, 1, 70); em = clip(em + 70);
    both("R5 miss saturates");

    wr(4'b0111);
    check("R2 readback hold", int'(ctl_q), 7);
    pulses(1, 1, 4); eh = 0;
    both("R6 hit held at zero");

    wr(4'b0011);
    pulses(1, 0, 2); eh = 2;
    both("R7 resume from zero");

    wr(4'b1100); eh = 0; em = 0;
    pulses(1, 1, 3);
    both("R6 both held, not running");
    wr(4'b0000);
    pulses(1, 1, 3);
    both("R4 released not running");

    wr(4'b0011);
    pulses(1, 1, 9); eh = 9; em = 9;
    both("R8 simultaneous");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0; eh = 0; em = 0;
    both("R1 reset mid run");
    check("R1 ctl mid run", int'(ctl_q), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule